// File: doc/BRIEF.md
# Delayed Write Retry Controller

A bridge forwards a delayed write onto a target bus and repeats it until the write is settled. After each attempt, the master-side sequencer pulses a strobe and presents the attempt's termination code and a flag that says whether any data phase moved. This controller decides what happens next. It can ask for another attempt, end the transaction with the code the target gave, or give up once target retries have used up their budget.

A new transaction is opened with a load pulse. The load also says whether the write was posted, and it picks one of two retry budgets. Target retries are counted against the chosen budget (2^DEF_LOG2 or 2^MAX_LOG2 retries; 2^24 and 2^32 by default). When the last allowed retry arrives, the transaction is declared not delivered. At that point a system-error request may pulse, depending on an enable bit and a per-event mask bit. A sticky status bit keeps a record of the request until software clears it. The termination of a delayed write is handed back to the original initiator through a report strobe. A posted write never produces one.

Top module: `dw_retry_ctrl`

## Requirements
- R1: Each accepted attempt strobe produces exactly one of reattempt_o, done_o or failed_o, high for one cycle at the first rising edge after the strobe. term_o carries a code in that same cycle and is 0 in every other cycle. The input codes are 0 normal, 1 target retry, 2 target disconnect, 3 target abort and 4 master abort. The output code 5 means not delivered.
- R2: A target retry below the budget gives reattempt_o with term_o=1 and adds one to the retry count.
- R3: A disconnect with att_data_i=1 gives done_o with term_o=2. A disconnect without data gives reattempt_o with term_o=2 and does not add to the retry count.
- R4: A normal completion gives done_o with term_o=0.
- R5: A target abort or a master abort gives done_o at once, with term_o=3 or 4 respectively.
- R6: With limit_max_i=0 latched at load, the 2^DEF_LOG2-th target retry of a transaction gives failed_o with term_o=5. With limit_max_i=1, the 2^MAX_LOG2-th target retry does so. Every earlier retry gives reattempt_o.
- R7: load_i clears the retry count, latches limit_max_i and posted_i, and restarts an open transaction. An attempt strobe in the same cycle as load_i is ignored.
- R8: An attempt strobe while no transaction is open produces no output.
- R9: sys_err_o pulses together with failed_o only when sys_err_en_i=1 and undeliv_mask_i=0 in the strobe cycle.
- R10: sys_err_sts_o rises with each sys_err_o pulse and stays high until a cycle with sts_clr_i=1. A new pulse in that same cycle keeps it high.
- R11: report_o accompanies done_o or failed_o for a delayed write and is never high for a posted write.
- R12: While reset is held and just after it is released, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Opens a new transaction |
| posted_i | input | 1 | With load_i: 1 means the write is posted |
| limit_max_i | input | 1 | With load_i: 1 selects the larger retry budget |
| att_done_i | input | 1 | One attempt has finished |
| att_term_i | input | 3 | Termination code of that attempt |
| att_data_i | input | 1 | At least one data phase completed in that attempt |
| sys_err_en_i | input | 1 | System-error enable bit |
| undeliv_mask_i | input | 1 | Suppresses the system error for non-delivery |
| sts_clr_i | input | 1 | Clears the sticky system-error status |
| reattempt_o | output | 1 | Repeat the write |
| done_o | output | 1 | Transaction ended with the code in term_o |
| failed_o | output | 1 | Retry budget exhausted, not delivered |
| term_o | output | 3 | Code that goes with the result |
| report_o | output | 1 | Termination is returned to the initiator |
| sys_err_o | output | 1 | One-cycle system-error request |
| sys_err_sts_o | output | 1 | Sticky record of a system-error request |

## Verification
Every result output, as well as sys_err_o and the setting of sys_err_sts_o, is registered once from the strobe. Each of them is therefore due at the first rising edge after the cycle in which the strobe is driven. The bench drives inputs on the falling edge and releases them one nanosecond after the next rising edge. It compares all outputs at that same instant, so every vector is judged exactly one edge after its stimulus. A clear request takes effect at the edge that samples it, and the bench checks it in the same way. The small budgets used by the bench (4 and 8 retries) let the exhaustion cycle be counted exactly.

// File: rtl/dwr_pkg.sv
package dwr_pkg;

    typedef enum logic [2:0] {
        TERM_NORMAL  = 3'd0,
        TERM_RETRY   = 3'd1,
        TERM_DISC    = 3'd2,
        TERM_TABORT  = 3'd3,
        TERM_MABORT  = 3'd4,
        TERM_UNDELIV = 3'd5
    } term_e;

    typedef enum logic [1:0] {
        ACT_FINISH = 2'd0,
        ACT_RETRY  = 2'd1,
        ACT_AGAIN  = 2'd2
    } act_e;

endpackage

// File: rtl/dwr_classify.sv
module dwr_classify
    import dwr_pkg::*;
(
    input  logic [2:0] code_i,
    input  logic       data_i,
    output act_e       act_o,
    output logic [2:0] code_o
);

    always_comb begin
        act_o  = ACT_FINISH;
        code_o = code_i;
        case (code_i)
            TERM_NORMAL: act_o = ACT_FINISH;
            TERM_RETRY:  act_o = ACT_RETRY;
            TERM_DISC:   act_o = data_i ? ACT_FINISH : ACT_AGAIN;
            TERM_TABORT: act_o = ACT_FINISH;
            TERM_MABORT: act_o = ACT_FINISH;
            default: begin
                // undefined codes end the write as a target abort
                act_o  = ACT_FINISH;
                code_o = TERM_TABORT;
            end
        endcase
    end

endmodule

// File: rtl/dwr_retry_cnt.sv
module dwr_retry_cnt #(
    parameter int CNT_W    = 32,
    parameter int DEF_LOG2 = 24,
    parameter int MAX_LOG2 = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic sel_i,
    input  logic inc_i,
    output logic last_o
);

    localparam logic [CNT_W-1:0] DEF_LAST = CNT_W'((64'd1 << DEF_LOG2) - 64'd1);
    localparam logic [CNT_W-1:0] MAX_LAST = CNT_W'((64'd1 << MAX_LOG2) - 64'd1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sel;
    } cnt_st_t;

    cnt_st_t cs_d, cs_q;
    logic [CNT_W-1:0] lim_last;

    assign lim_last = cs_q.sel ? MAX_LAST : DEF_LAST;
    assign last_o   = (cs_q.cnt == lim_last);

    always_comb begin
        cs_d = cs_q;
        if (clear_i) begin
            cs_d.cnt = '0;
            cs_d.sel = sel_i;
        end else if (inc_i) begin
            cs_d.cnt = cs_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q.cnt <= lim_last);

    p_no_inc_at_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |-> !last_o);

endmodule

// File: rtl/dwr_syserr.sv
module dwr_syserr (
    input  logic clk,
    input  logic rst_n,
    input  logic exhaust_i,
    input  logic en_i,
    input  logic mask_i,
    input  logic clr_i,
    output logic pulse_o,
    output logic sticky_o
);

    typedef struct packed {
        logic pulse;
        logic sticky;
    } se_st_t;

    se_st_t se_d, se_q;

    always_comb begin
        se_d       = se_q;
        se_d.pulse = exhaust_i && en_i && !mask_i;
        if (se_d.pulse)  se_d.sticky = 1'b1;
        else if (clr_i)  se_d.sticky = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) se_q <= '0;
        else        se_q <= se_d;
    end

    assign pulse_o  = se_q.pulse;
    assign sticky_o = se_q.sticky;

    p_sticky_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_o && !$past(sticky_o)) |-> pulse_o);

    p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);

endmodule

// File: rtl/dw_retry_ctrl.sv
module dw_retry_ctrl
    import dwr_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int DEF_LOG2 = 24,
    parameter int MAX_LOG2 = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic       posted_i,
    input  logic       limit_max_i,
    input  logic       att_done_i,
    input  logic [2:0] att_term_i,
    input  logic       att_data_i,
    input  logic       sys_err_en_i,
    input  logic       undeliv_mask_i,
    input  logic       sts_clr_i,
    output logic       reattempt_o,
    output logic       done_o,
    output logic       failed_o,
    output logic [2:0] term_o,
    output logic       report_o,
    output logic       sys_err_o,
    output logic       sys_err_sts_o
);

    typedef struct packed {
        logic       active;
        logic       posted;
        logic       reattempt;
        logic       done;
        logic       failed;
        logic [2:0] term;
        logic       report;
    } ctl_st_t;

    ctl_st_t st_d, st_q;
    act_e       act;
    logic [2:0] code_n;
    logic       take, cnt_last, cnt_inc, exhaust;

    assign take = st_q.active && att_done_i && !load_i;

    dwr_classify u_cls (
        .code_i (att_term_i),
        .data_i (att_data_i),
        .act_o  (act),
        .code_o (code_n)
    );

    dwr_retry_cnt #(
        .CNT_W    (CNT_W),
        .DEF_LOG2 (DEF_LOG2),
        .MAX_LOG2 (MAX_LOG2)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (load_i),
        .sel_i   (limit_max_i),
        .inc_i   (cnt_inc),
        .last_o  (cnt_last)
    );

    dwr_syserr u_se (
        .clk       (clk),
        .rst_n     (rst_n),
        .exhaust_i (exhaust),
        .en_i      (sys_err_en_i),
        .mask_i    (undeliv_mask_i),
        .clr_i     (sts_clr_i),
        .pulse_o   (sys_err_o),
        .sticky_o  (sys_err_sts_o)
    );

    always_comb begin
        st_d           = st_q;
        st_d.reattempt = 1'b0;
        st_d.done      = 1'b0;
        st_d.failed    = 1'b0;
        st_d.term      = TERM_NORMAL;
        st_d.report    = 1'b0;
        cnt_inc        = 1'b0;
        exhaust        = 1'b0;
        if (load_i) begin
            st_d.active = 1'b1;
            st_d.posted = posted_i;
        end else if (take) begin
            case (act)
                ACT_FINISH: begin
                    st_d.done   = 1'b1;
                    st_d.term   = code_n;
                    st_d.report = !st_q.posted;
                    st_d.active = 1'b0;
                end
                ACT_RETRY: begin
                    if (cnt_last) begin
                        st_d.failed = 1'b1;
                        st_d.term   = TERM_UNDELIV;
                        st_d.report = !st_q.posted;
                        st_d.active = 1'b0;
                        exhaust     = 1'b1;
                    end else begin
                        st_d.reattempt = 1'b1;
                        st_d.term      = code_n;
                        cnt_inc        = 1'b1;
                    end
                end
                ACT_AGAIN: begin
                    st_d.reattempt = 1'b1;
                    st_d.term      = code_n;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reattempt_o = st_q.reattempt;
    assign done_o      = st_q.done;
    assign failed_o    = st_q.failed;
    assign term_o      = st_q.term;
    assign report_o    = st_q.report;

    p_onehot_result_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reattempt_o, done_o, failed_o}));

    p_result_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reattempt_o || done_o || failed_o) |-> $past(att_done_i && st_q.active && !load_i));

    p_undeliv_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        failed_o |-> (term_o == TERM_UNDELIV));

    p_syserr_with_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sys_err_o |-> failed_o);

    p_report_delayed_r11: assert property (@(posedge clk) disable iff (!rst_n)
        report_o |-> ((done_o || failed_o) && !$past(st_q.posted)));

endmodule

// File: tb/sim_dw_retry_ctrl.sv
`timescale 1ns/100ps
module sim_dw_retry_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_i = 1'b0, posted_i = 1'b0, limit_max_i = 1'b0;
    logic       att_done_i = 1'b0, att_data_i = 1'b0;
    logic [2:0] att_term_i = 3'd0;
    logic       sys_err_en_i = 1'b0, undeliv_mask_i = 1'b0, sts_clr_i = 1'b0;
    logic       reattempt_o, done_o, failed_o, report_o, sys_err_o, sys_err_sts_o;
    logic [2:0] term_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dw_retry_ctrl #(.CNT_W(8), .DEF_LOG2(2), .MAX_LOG2(3)) u0 (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .posted_i(posted_i),
        .limit_max_i(limit_max_i), .att_done_i(att_done_i), .att_term_i(att_term_i),
        .att_data_i(att_data_i), .sys_err_en_i(sys_err_en_i),
        .undeliv_mask_i(undeliv_mask_i), .sts_clr_i(sts_clr_i),
        .reattempt_o(reattempt_o), .done_o(done_o), .failed_o(failed_o),
        .term_o(term_o), .report_o(report_o), .sys_err_o(sys_err_o),
        .sys_err_sts_o(sys_err_sts_o)
    );

    typedef struct packed {
        logic       ld, pst, sel, stb;
        logic [2:0] code;
        logic       dat, en, dis;
        logic       re, dn, fl;
        logic [2:0] term;
        logic       rep, se;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,3'd0,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b1,3'd1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,3'd1,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b1,3'd2,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,3'd2,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b1,3'd1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,3'd1,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b1,3'd0,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0,3'd0,1'b1,1'b0},
        '{1'b0,1'b0,1'b0,1'b1,3'd1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,3'd0,1'b0,1'b0},
        '{1'b1,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,3'd0,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b1,3'd1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,3'd1,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b1,3'd1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,3'd1,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b1,3'd1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,3'd1,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b1,3'd1,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b1,3'd5,1'b1,1'b1},
        '{1'b1,1'b1,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,3'd0,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b1,3'd2,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0,3'd2,1'b0,1'b0},
        '{1'b1,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,3'd0,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b1,3'd3,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,3'd3,1'b1,1'b0},
        '{1'b1,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,3'd0,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b1,3'd4,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,3'd4,1'b1,1'b0},
        '{1'b1,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,3'd0,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b1,3'd1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,3'd1,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b1,3'd2,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,3'd2,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b1,3'd1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,3'd1,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b1,3'd1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,3'd1,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b1,3'd1,1'b0,1'b1,1'b1, 1'b0,1'b0,1'b1,3'd5,1'b1,1'b0}
    };

    task automatic chk(input string tag, input string what, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic drive(input logic ld, input logic pst, input logic sel, input logic stb,
                         input logic [2:0] code, input logic dat, input logic en,
                         input logic dis, input logic clr);
        @(negedge clk);
        load_i = ld; posted_i = pst; limit_max_i = sel; att_done_i = stb;
        att_term_i = code; att_data_i = dat; sys_err_en_i = en;
        undeliv_mask_i = dis; sts_clr_i = clr;
        @(posedge clk);
        #1;
        load_i = 1'b0; posted_i = 1'b0; limit_max_i = 1'b0; att_done_i = 1'b0;
        att_term_i = 3'd0; att_data_i = 1'b0; sys_err_en_i = 1'b0;
        undeliv_mask_i = 1'b0; sts_clr_i = 1'b0;
    endtask

    task automatic expect_res(input string tag, input logic re, input logic dn, input logic fl,
                              input logic [2:0] tm, input logic rep, input logic se);
        chk(tag, "reattempt", {3'd0, reattempt_o}, {3'd0, re});
        chk(tag, "done",      {3'd0, done_o},      {3'd0, dn});
        chk(tag, "failed",    {3'd0, failed_o},    {3'd0, fl});
        chk(tag, "term",      {1'b0, term_o},      {1'b0, tm});
        chk("R11", "report",  {3'd0, report_o},    {3'd0, rep});
        chk("R9",  "sys_err", {3'd0, sys_err_o},   {3'd0, se});
    endtask

    function automatic string tag_of(input vec_t v);
        if (v.fl) return "R6";
        if (v.dn) return (v.code == 3'd3 || v.code == 3'd4) ? "R5" : (v.code == 3'd2 ? "R3" : "R4");
        if (v.re) return (v.code == 3'd2) ? "R3" : "R2";
        if (v.stb) return "R8";
        return "R7";
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R12: reset state
        repeat (3) @(posedge clk);
        #1;
        expect_res("R12", 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0);
        chk("R12", "sts", {3'd0, sys_err_sts_o}, 4'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        expect_res("R12", 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0);

        // R1..R11: vector table
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].ld, VEC[i].pst, VEC[i].sel, VEC[i].stb, VEC[i].code,
                  VEC[i].dat, VEC[i].en, VEC[i].dis, 1'b0);
            expect_res(tag_of(VEC[i]), VEC[i].re, VEC[i].dn, VEC[i].fl,
                       VEC[i].term, VEC[i].rep, VEC[i].se);
        end

        // R10: sticky held since the table's system error, then cleared
        chk("R10", "sts held", {3'd0, sys_err_sts_o}, 4'd1);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R10", "sts cleared", {3'd0, sys_err_sts_o}, 4'd0);

        // R6: larger budget, eight retries
        drive(1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 7; k++) begin
            drive(1'b0, 1'b0, 1'b0, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0);
            expect_res("R6", 1'b1, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0);
        end
        // R10: set wins over a simultaneous clear
        drive(1'b0, 1'b0, 1'b0, 1'b1, 3'd1, 1'b0, 1'b1, 1'b0, 1'b1);
        expect_res("R6", 1'b0, 1'b0, 1'b1, 3'd5, 1'b1, 1'b1);
        chk("R10", "set beats clear", {3'd0, sys_err_sts_o}, 4'd1);

        // R7: reload mid-transaction clears the count; strobe with load ignored
        drive(1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++)
            drive(1'b0, 1'b0, 1'b0, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b0, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_res("R7", 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) begin
            drive(1'b0, 1'b0, 1'b0, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0);
            expect_res("R7", 1'b1, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0);
        end
        // R9: enable low, so no request on exhaustion
        drive(1'b0, 1'b0, 1'b0, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_res("R9", 1'b0, 1'b0, 1'b1, 3'd5, 1'b1, 1'b0);

        // R11: posted write exhausting gives no report
        drive(1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++)
            drive(1'b0, 1'b0, 1'b0, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_res("R11", 1'b0, 1'b0, 1'b1, 3'd5, 1'b0, 1'b1);

        // R1: outputs last one cycle only
        drive(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_res("R1", 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule